// File: doc/BRIEF.md
# Power-On Strap Sampling Controller

This block sequences a set of dual-purpose pads that are read as configuration straps right after power-up and are driven as clock outputs from then on. It waits for the supply-good flag, then counts a fixed sampling window in reference-clock cycles. During that window every pad driver is kept in high impedance, so the external strap resistors alone set the pad levels. When the window ends, the synchronized pad levels are captured and the drivers are switched on.

The captured configuration is sticky. After the capture, pad levels and the supply-good flag no longer affect it. Only the power-on reset `rst_ni`, which stands for a full removal and return of power, clears it. Once the drivers are enabled, the clock output is held low for a short guard interval before it may start toggling, so the pad leaves high impedance at a defined level.

The default window is 28,636 cycles of a 14.318 MHz reference, which is about 2 ms. If supply-good drops before the window ends, the count starts again from zero.

Top module: `strap_sampler`

## Requirements
- R1: While `rst_ni` is low, `oe_o` is all zeros, `cfg_o` is all zeros and `hold_low_o` is 1.
- R2: While `supply_ok_i` stays low, no window starts, and `oe_o` stays all zeros for any number of cycles.
- R3: Take the first rising clock edge at which `supply_ok_i` is seen high as edge 0. `oe_o` stays zero through edge `WINDOW_CYCLES-1` and becomes nonzero at edge `WINDOW_CYCLES`.
- R4: At capture, bit i of `cfg_o` is 0 if pad i was low and 1 if it was high. This holds when the pad level has been stable for at least `SYNC_STAGES+1` cycles before the capture edge.
- R5: All bits of `oe_o` become 1 on the same edge, and once set they stay 1 until the next reset.
- R6: `hold_low_o` stays 1 for exactly `HOLD_CYCLES` cycles after `oe_o` becomes 1, then drops to 0. It is 1 in every cycle before the drivers are enabled.
- R7: If `supply_ok_i` is seen low at any edge inside the window, the window restarts from zero. A full `WINDOW_CYCLES` count is then needed after supply-good returns.
- R8: After capture, changes on `strap_i` and on `supply_ok_i` leave `cfg_o`, `oe_o` and `hold_low_o` unchanged.
- R9: A new `rst_ni` pulse clears the captured bits. The next window then captures the pad levels present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| supply_ok_i | input | 1 | Supply-good flag from the analog detector |
| strap_i | input | N_PINS | Input levels sensed on the dual-purpose pads |
| oe_o | output | N_PINS | Pad output-driver enables, 1 = drive |
| cfg_o | output | N_PINS | Captured configuration bits |
| hold_low_o | output | 1 | Forces the clock output low while 1 |

## Verification
The assertions take for granted that `strap_i` is quiet for the last few cycles of the window. They also take `rst_ni` to be the only way out of the enabled phase. Apart from that they expect nothing from `supply_ok_i`, which may glitch at any time. The stimulus sets the pad levels before supply-good rises and keeps them fixed through each window. It changes them only after the capture, or while reset is held. Supply-good is driven on falling edges only, at a single-cycle low inside a window and as a multi-cycle drop after the capture.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;
endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
  parameter int N_PINS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] d_i,
  output logic [N_PINS-1:0] q_o
);
  logic [SYNC_STAGES-1:0][N_PINS-1:0] stage_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/psc_window_timer.sv
module psc_window_timer
  import psc_pkg::*;
#(
  parameter int WINDOW_CYCLES = 28636,
  localparam int CNT_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  output logic capture_o,
  output logic done_o,
  output logic busy_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (supply_ok_i) phase_q <= PH_COUNT;
        end
        PH_COUNT: begin
          if (!supply_ok_i) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else if (cnt_q == LAST) begin
            phase_q <= PH_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_DONE;
      endcase
    end
  end

  assign capture_o = (phase_q == PH_COUNT) && supply_ok_i && (cnt_q == LAST);
  assign done_o    = (phase_q == PH_DONE);
  assign busy_o    = (phase_q == PH_COUNT);

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R3
  AST_RESTART_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !supply_ok_i) |=> (cnt_q == '0 && !busy_o && !done_o)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R8
endmodule

// File: rtl/psc_strap_latch.sv
module psc_strap_latch #(
  parameter int N_PINS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [N_PINS-1:0] level_i,
  output logic [N_PINS-1:0] cfg_o
);
  logic [N_PINS-1:0] cfg_q;

  for (genvar i = 0; i < N_PINS; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[i] <= 1'b0;
      else if (capture_i) cfg_q[i] <= level_i[i];
    end
  end

  assign cfg_o = cfg_q;

  AST_CFG_ONLY_AT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> $past(capture_i)); // R8
  AST_CAPTURE_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (cfg_q == $past(level_i))); // R4
endmodule

// File: rtl/psc_drive_ctrl.sv
module psc_drive_ctrl #(
  parameter int N_PINS      = 4,
  parameter int HOLD_CYCLES = 4,
  localparam int HCNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  output logic [N_PINS-1:0] oe_o,
  output logic              hold_low_o
);
  localparam logic [HCNT_W-1:0] HLAST = HCNT_W'(HOLD_CYCLES - 1);

  logic              drive_q;
  logic              release_q;
  logic [HCNT_W-1:0] hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_q <= 1'b0;
    else if (capture_i) drive_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q    <= '0;
      release_q <= 1'b0;
    end else if (drive_q && !release_q) begin
      if (hcnt_q == HLAST) release_q <= 1'b1;
      else hcnt_q <= hcnt_q + 1'b1;
    end
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_oe
    assign oe_o[i] = drive_q;
  end
  assign hold_low_o = !release_q;

  AST_OE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_q |=> drive_q); // R5
  AST_HOLD_AFTER_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_low_o) |-> $past(drive_q)); // R6
  AST_HOLD_WHILE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_q |-> hold_low_o); // R6
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler #(
  parameter int N_PINS        = 4,
  parameter int WINDOW_CYCLES = 28636,
  parameter int HOLD_CYCLES   = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_ok_i,
  input  logic [N_PINS-1:0] strap_i,
  output logic [N_PINS-1:0] oe_o,
  output logic [N_PINS-1:0] cfg_o,
  output logic              hold_low_o
);
  logic [N_PINS-1:0] level_sync;
  logic              capture;
  logic              win_done;
  logic              win_busy;

  psc_sync #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (strap_i),
    .q_o   (level_sync)
  );

  psc_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .capture_o  (capture),
    .done_o     (win_done),
    .busy_o     (win_busy)
  );

  psc_strap_latch #(.N_PINS(N_PINS)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .level_i  (level_sync),
    .cfg_o    (cfg_o)
  );

  psc_drive_ctrl #(.N_PINS(N_PINS), .HOLD_CYCLES(HOLD_CYCLES)) u_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .oe_o      (oe_o),
    .hold_low_o(hold_low_o)
  );

  AST_NO_OE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_done |-> (oe_o == '0)); // R3
  AST_OE_ALL_OR_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o == '0) || (oe_o == '1)); // R5
  AST_NO_OE_WITHOUT_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_busy && !win_done) |-> (oe_o == '0)); // R2
endmodule

// File: tb/strap_sampler_tb.sv
module strap_sampler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int WIN  = 64;
  localparam int HOLD = 4;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         supply_ok = 1'b0;
  logic [N-1:0] strap = '0;
  logic [N-1:0] oe, cfg;
  logic         hold_low;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_sampler #(.N_PINS(N), .WINDOW_CYCLES(WIN), .HOLD_CYCLES(HOLD),
                  .SYNC_STAGES(SYNC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .strap_i(strap),
    .oe_o(oe), .cfg_o(cfg), .hold_low_o(hold_low)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_cycle();
    supply_ok = 1'b0;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  // full window with given straps, checks exact timing
  task automatic run_window(input logic [N-1:0] pads, input string tag);
    strap = pads;
    step(SYNC + 1);
    supply_ok = 1'b1;
    step(WIN);
    chk("R3", {tag, " oe before end"}, 32'(oe), 32'(0));
    step(1);
    chk("R3", {tag, " oe at end"}, 32'(oe), 32'({N{1'b1}}));
    chk("R5", {tag, " oe all set"}, 32'(oe), 32'({N{1'b1}}));
    chk("R4", {tag, " captured"}, 32'(cfg), 32'(pads));
    chk("R6", {tag, " hold at enable"}, 32'(hold_low), 32'(1));
    step(HOLD - 1);
    chk("R6", {tag, " hold last cycle"}, 32'(hold_low), 32'(1));
    step(1);
    chk("R6", {tag, " hold released"}, 32'(hold_low), 32'(0));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(2);
    chk("R1", "oe in reset", 32'(oe), 32'(0));
    chk("R1", "cfg in reset", 32'(cfg), 32'(0));
    chk("R1", "hold in reset", 32'(hold_low), 32'(1));
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_no_supply();
    power_cycle();
    strap = 4'b1111;
    step(3 * WIN);
    chk("R2", "oe without supply", 32'(oe), 32'(0));
    chk("R2", "hold without supply", 32'(hold_low), 32'(1));
  endtask

  task automatic t_sticky();
    logic [N-1:0] keep;
    keep = cfg;
    strap = ~strap;
    supply_ok = 1'b0;
    step(WIN + 5);
    chk("R8", "cfg after pad and supply change", 32'(cfg), 32'(keep));
    chk("R8", "oe after supply drop", 32'(oe), 32'({N{1'b1}}));
    chk("R8", "hold after supply drop", 32'(hold_low), 32'(0));
    supply_ok = 1'b1;
    step(2 * WIN);
    chk("R8", "cfg after supply return", 32'(cfg), 32'(keep));
    chk("R8", "oe after supply return", 32'(oe), 32'({N{1'b1}}));
  endtask

  task automatic t_restart();
    power_cycle();
    strap = 4'b0110;
    step(SYNC + 1);
    supply_ok = 1'b1;
    step(WIN / 2);
    supply_ok = 1'b0;
    step(1);
    chk("R7", "oe after drop", 32'(oe), 32'(0));
    supply_ok = 1'b1;
    step(WIN);
    chk("R7", "oe before full recount", 32'(oe), 32'(0));
    step(1);
    chk("R7", "oe after full recount", 32'(oe), 32'({N{1'b1}}));
    chk("R7", "cfg after recount", 32'(cfg), 32'(4'b0110));
  endtask

  task automatic t_repower();
    power_cycle();
    chk("R9", "cfg cleared by power cycle", 32'(cfg), 32'(0));
    chk("R9", "oe cleared by power cycle", 32'(oe), 32'(0));
    run_window(4'b0101, "R9 second");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    run_window(4'b1010, "first");
    t_sticky();
    t_repower();
    run_window_all();
    t_restart();
    t_no_supply();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  task automatic run_window_all();
    power_cycle();
    run_window(4'b1111, "all high");
    power_cycle();
    run_window(4'b0000, "all low");
  endtask
endmodule